// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Glitch Filter

The block receives asynchronous serial frames of one start bit, eight data bits and one stop bit, with no parity. The block runs on a system clock. An external enable pulse, `tick_i`, arrives sixteen times per bit period. The raw line first passes through a two-flop synchronizer. A two-bit saturating up/down counter then cleans it, and its output has hysteresis.

The receiver waits in idle for a falling edge on the cleaned line. It then counts oversample ticks and samples each bit period on its seventh tick. A start bit that has returned high by that point is a false start and is dropped. Data is shifted in LSB first.

Each completed byte goes to a holding register. Delivery uses a toggle handshake that needs no shared clock. The receiver flips `req_o`, and the consumer flips `ack_i` once it has taken `data_o`. A byte that arrives while the previous one is still untaken is dropped, and the overrun flag is raised. A byte whose stop bit samples low is also dropped, and the framing flag is raised. Both flags stay set until `clr_i` is pulsed.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `req_o` is 0, `data_o` is 0x00, and `frame_err_o` and `overrun_o` are 0.
- R2: A low pulse on `rx_i` that lasts a single tick on an idle line is filtered out. It starts no frame, does not change `req_o` and sets no flag.
- R3: A frame sent at 16 ticks per bit is received. The start bit is low, bits 0 to 7 follow LSB first, and the stop bit is high. Each bit is sampled on the 7th tick of its period.
- R4: If the cleaned line is high again at the start bit's sample point, the frame is abandoned as a false start. `req_o`, `data_o` and both flags stay unchanged.
- R5: If the stop bit samples low, `frame_err_o` is set. The byte is dropped, and `req_o` and `data_o` stay unchanged.
- R6: Each good byte that arrives while `req_o` equals the synchronized `ack_i` loads `data_o` and toggles `req_o` exactly once. `req_o` changes at no other time.
- R7: If a good byte completes while `req_o` differs from the synchronized `ack_i`, `overrun_o` is set. The new byte is dropped, `data_o` keeps the untaken byte and `req_o` does not toggle.
- R8: `frame_err_o` and `overrun_o` stay set until a one-cycle `clr_i` pulse clears them. If a flag event and `clr_i` fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable, 16 pulses per bit |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| ack_i | input | 1 | Toggle from the consumer: byte taken |
| clr_i | input | 1 | Synchronous clear of both error flags |
| req_o | output | 1 | Toggles when a new byte is in `data_o` |
| data_o | output | 8 | Holding register with the last delivered byte |
| frame_err_o | output | 1 | Sticky framing error flag |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
If the bit position or sample tick counter is off, the error shows up in the same frame. Either `data_o` holds a shifted or wrong byte when `req_o` toggles, or `frame_err_o` rises at the stop bit, within one frame time.

If the filter counter or the hysteresis is wrong, glitches or false starts start frames. These appear as extra `req_o` toggles or framing errors about ten bit periods later.

If the handshake compare is wrong, `req_o` toggles on a byte that should have been an overrun, or `data_o` is overwritten. This is visible at the end of the second unacknowledged frame.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_line_filter.sv
module rx_line_filter #(
  parameter int FILT_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  output logic line_o
);
  localparam logic [FILT_W-1:0] CNT_MAX = {FILT_W{1'b1}};

  logic [1:0]        sync_q;
  logic [FILT_W-1:0] cnt_q;
  logic              line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_MAX;
    end else if (tick_i) begin
      if (sync_q[1] && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
      else if (!sync_q[1] && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // hysteresis: only saturation moves the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               line_q <= 1'b1;
    else if (cnt_q == CNT_MAX) line_q <= 1'b1;
    else if (cnt_q == '0)      line_q <= 1'b0;
  end

  assign line_o = line_q;

  // R2
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sync_q[1] && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R2
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sync_q[1] && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SAMPLE_TICK = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              done_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int TCNT_W = $clog2(OVS);
  localparam int BCNT_W = $clog2(DATA_W);
  localparam logic [TCNT_W-1:0] T_SAMPLE = TCNT_W'(SAMPLE_TICK - 1);
  localparam logic [TCNT_W-1:0] T_LAST   = TCNT_W'(OVS - 1);
  localparam logic [BCNT_W-1:0] B_LAST   = BCNT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              line_prev_q;
  logic              sample_hit;

  assign sample_hit = tick_i && tcnt_q == T_SAMPLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_prev_q <= 1'b1;
    else         line_prev_q <= line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (line_prev_q && !line_i) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
          end
        end
        default: begin
          if (tick_i) begin
            tcnt_q <= (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
            if (sample_hit && state_q == ST_DATA)
              shift_q <= {line_i, shift_q[DATA_W-1:1]};
            if (sample_hit && state_q == ST_START && line_i) begin
              state_q <= ST_IDLE; // false start
            end else if (sample_hit && state_q == ST_STOP) begin
              state_q <= ST_IDLE;
            end else if (tcnt_q == T_LAST) begin
              if (state_q == ST_START) begin
                state_q <= ST_DATA;
                bcnt_q  <= '0;
              end else if (state_q == ST_DATA) begin
                if (bcnt_q == B_LAST) state_q <= ST_STOP;
                else                  bcnt_q  <= bcnt_q + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assign done_o    = state_q == ST_STOP && sample_hit;
  assign stop_ok_o = line_i;
  assign byte_o    = shift_q;

  // R3
  stop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_STOP) |-> $past(state_q == ST_DATA));
  // R4
  start_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_START) |-> $past(state_q == ST_IDLE));
endmodule

// File: rtl/rx_handoff.sv
module rx_handoff #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              stop_ok_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              ack_i,
  input  logic              clr_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic [1:0]        ack_sync_q;
  logic              req_q, ferr_q, ovr_q;
  logic [DATA_W-1:0] data_q;
  logic              pending;

  assign pending = req_q ^ ack_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_sync_q <= '0;
    else         ack_sync_q <= {ack_sync_q[0], ack_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (clr_i) begin
        ferr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (done_i) begin
        if (!stop_ok_i) ferr_q <= 1'b1;
        else if (pending) ovr_q <= 1'b1;
        else begin
          data_q <= byte_i;
          req_q  <= ~req_q;
        end
      end
    end
  end

  assign req_o       = req_q;
  assign data_o      = data_q;
  assign frame_err_o = ferr_q;
  assign overrun_o   = ovr_q;

  // R6
  req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(req_q));
  // R7
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && pending) |=> ($stable(data_q) && $stable(req_q)));
  // R8
  ferr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_q && !clr_i) |=> ferr_q);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_i) |=> ovr_q);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SAMPLE_TICK = 7,
  parameter int FILT_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              ack_i,
  input  logic              clr_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              line;
  logic              done;
  logic              stop_ok;
  logic [DATA_W-1:0] rx_byte;

  rx_line_filter #(.FILT_W(FILT_W)) i_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rx_i  (rx_i),
    .line_o(line)
  );

  rx_frame_fsm #(
    .DATA_W     (DATA_W),
    .OVS        (OVS),
    .SAMPLE_TICK(SAMPLE_TICK)
  ) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .line_i   (line),
    .done_o   (done),
    .stop_ok_o(stop_ok),
    .byte_o   (rx_byte)
  );

  rx_handoff #(.DATA_W(DATA_W)) i_handoff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .stop_ok_i  (stop_ok),
    .byte_i     (rx_byte),
    .ack_i      (ack_i),
    .clr_i      (clr_i),
    .req_o      (req_o),
    .data_o     (data_o),
    .frame_err_o(frame_err_o),
    .overrun_o  (overrun_o)
  );
endmodule

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
  localparam int TICK_DIV = 4;
  localparam int OVS      = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       ack_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       req_o;
  logic [7:0] data_o;
  logic       frame_err_o;
  logic       overrun_o;

  int checks = 0;
  int errors = 0;
  logic       exp_req = 1'b0;
  logic [7:0] exp_data = 8'h00;

  always #2.5 clk_i = ~clk_i;

  uart_os_rx i_uart_os_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_i),
    .ack_i(ack_i), .clr_i(clr_i), .req_o(req_o), .data_o(data_o),
    .frame_err_o(frame_err_o), .overrun_o(overrun_o)
  );

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_bit);
    rx_i = 1'b0;
    wait_ticks(OVS);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      wait_ticks(OVS);
    end
    rx_i = stop_bit;
    wait_ticks(OVS);
    rx_i = 1'b1;
    wait_ticks(3);
  endtask

  task automatic give_ack();
    ack_i = ~ack_i;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic check_outputs(input string tag, input logic fe, input logic ov);
    chk(req_o == exp_req, {tag, " req"}, req_o, exp_req);
    chk(data_o == exp_data, {tag, " data"}, data_o, exp_data);
    chk(frame_err_o == fe, {tag, " frame_err"}, frame_err_o, fe);
    chk(overrun_o == ov, {tag, " overrun"}, overrun_o, ov);
  endtask

  function automatic logic [7:0] pick_byte(input int i);
    logic [7:0] r;
    r = 8'($urandom());
    if (i == 0) r = 8'h00;
    if (i == 1) r = 8'hFF;
    if (i == 2) r = 8'h55;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R1 reset state
    check_outputs("R1", 1'b0, 1'b0);

    // R2 single-tick glitch
    rx_i = 1'b0;
    wait_ticks(1);
    rx_i = 1'b1;
    wait_ticks(200);
    check_outputs("R2", 1'b0, 1'b0);

    // R4 short low pulse: false start
    rx_i = 1'b0;
    wait_ticks(5);
    rx_i = 1'b1;
    wait_ticks(200);
    check_outputs("R4", 1'b0, 1'b0);

    // R3 R6 directed and random bytes with acknowledge
    for (int i = 0; i < 12; i++) begin
      logic [7:0] b;
      b = pick_byte(i);
      send_frame(b, 1'b1);
      exp_req  = ~exp_req;
      exp_data = b;
      check_outputs("R3 R6", 1'b0, 1'b0);
      give_ack();
      wait_ticks($urandom_range(0, 20));
    end

    // R7 overrun: two bytes without acknowledge
    send_frame(8'hA5, 1'b1);
    exp_req  = ~exp_req;
    exp_data = 8'hA5;
    check_outputs("R7 first", 1'b0, 1'b0);
    send_frame(8'h3C, 1'b1);
    check_outputs("R7 dropped", 1'b0, 1'b1);
    // R8 flag sticky until clr
    wait_ticks(30);
    chk(overrun_o == 1'b1, "R8 overrun held", overrun_o, 1);
    pulse_clr();
    check_outputs("R8 overrun cleared", 1'b0, 1'b0);
    give_ack();

    // R5 framing error
    send_frame(8'h96, 1'b0);
    check_outputs("R5", 1'b1, 1'b0);
    // R8 sticky across a good byte
    send_frame(8'h0F, 1'b1);
    exp_req  = ~exp_req;
    exp_data = 8'h0F;
    check_outputs("R8 ferr held", 1'b1, 1'b0);
    give_ack();
    pulse_clr();
    check_outputs("R8 ferr cleared", 1'b0, 1'b0);

    // R6 after recovery
    send_frame(8'hC3, 1'b1);
    exp_req  = ~exp_req;
    exp_data = 8'hC3;
    check_outputs("R6 recovery", 1'b0, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule